// File: doc/BRIEF.md
# Striped Test Frame Generator

This block synthesises a fixed test picture and hands it out one 16-bit pixel word at a time, in raster order (left to right along a line, then the next line down), to a consumer that writes it into frame memory. Each word travels under a valid/ready handshake. The current line and column indices and start-of-frame and end-of-frame markers travel with each word. The picture is a set of vertical colour bands that cycle red, then green, then blue. One full line is black.

A one-cycle `start` pulse launches a frame. The generator then offers pixels until the consumer accepts the final one. It then parks in a finished state with `frame_done` high and waits for the next pulse.

A small state machine has three states: `GEN_IDLE` (after reset, nothing offered), `GEN_RUN` (pixels offered) and `GEN_DONE` (frame complete). Its transitions are:

- *launch*: `GEN_IDLE` to `GEN_RUN`, on `start`.
- *finish*: `GEN_RUN` to `GEN_DONE`, when the last pixel is accepted.
- *relaunch*: `GEN_DONE` to `GEN_RUN`, on `start`.
- *reset*: any state to `GEN_IDLE`, on `rst`.

Top module: `stripe_frame_gen`

## Requirements
- R1: After a synchronous reset `out_valid` is 0, `out_row` and `out_col` are 0 and `frame_done` is 0.
- R2: A `start` pulse in the idle or finished state makes `out_valid` rise on the next cycle, with `out_row`=0, `out_col`=0 and `out_sof`=1.
- R3: Each accepted pixel (`out_valid` and `out_ready` both 1) advances `out_col` by exactly one. After column FRAME_W-1 (default 799), `out_col` returns to 0 and `out_row` increases by one, so every column is visited once per line.
- R4: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows the same `out_row`, `out_col` and `out_pixel`, and `out_valid` stays 1.
- R5: Pixels are RGB555 with bit 15 always 0: red in bits [14:10], green in [9:5] and blue in [4:0]. The band index is (column / STRIPE_W) mod 3, with STRIPE_W defaulting to 32. Index 0 gives 0x7C00 (red), index 1 gives 0x03E0 (green) and index 2 gives 0x001F (blue).
- R6: Every pixel on line BLACK_ROW (default 512) is 0x0000, whatever its band.
- R7: `out_eof` is 1 only on the pixel at line FRAME_H-1 (default 599), column FRAME_W-1. `out_sof` is 1 only on the pixel at line 0, column 0.
- R8: Once the last pixel is accepted, `out_valid` is 0 and `frame_done` is 1 from the next cycle until a `start` pulse. After that pulse, `frame_done` is 0 and the frame restarts at line 0, column 0.
- R9: A `start` pulse while a frame is in progress is ignored: the pixel sequence continues unchanged.
- R10: A reset in the middle of a frame returns the block to idle, with line and column at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches a frame |
| out_ready | input | 1 | Consumer accepts the offered pixel |
| out_valid | output | 1 | A pixel is offered |
| out_pixel | output | 16 | RGB555 pixel word, bit 15 zero |
| out_row | output | ROW_BITS | Line index of the offered pixel |
| out_col | output | COL_BITS | Column index of the offered pixel |
| out_sof | output | 1 | Offered pixel is the first of the frame |
| out_eof | output | 1 | Offered pixel is the last of the frame |
| frame_done | output | 1 | Frame complete, waiting for `start` |

## Verification
The following are checked on every cycle:

- The column stays in range and steps by one.
- Outputs hold while the consumer stalls.
- The end marker appears only at the last position.
- The first word is red.
- Bit 15 is clear.
- The block drops into the finished state right after the last accepted pixel.

Only the bench scenarios can show the rest:

- The full pixel sequence of whole frames under random back-pressure, including the exact band colours and the black line.
- That a `start` pulse during a frame leaves the sequence untouched.
- That a relaunch, and a reset in mid-frame, restart the count from line 0 and column 0.

// File: rtl/stripe_gen_pkg.sv
package stripe_gen_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_RUN  = 2'd1,
        GEN_DONE = 2'd2
    } gen_state_t;

    typedef enum logic [1:0] {
        BAND_RED   = 2'd0,
        BAND_GREEN = 2'd1,
        BAND_BLUE  = 2'd2
    } band_t;

    localparam int CHAN_BITS = 5;
    localparam logic [15:0] WORD_BLACK = 16'h0000;

    function automatic logic [15:0] pack_rgb555(input logic [CHAN_BITS-1:0] r,
                                                input logic [CHAN_BITS-1:0] g,
                                                input logic [CHAN_BITS-1:0] b);
        return {1'b0, r, g, b};
    endfunction

endpackage

// File: rtl/stripe_raster_cnt.sv
module stripe_raster_cnt
    import stripe_gen_pkg::*;
#(
    parameter int FRAME_W  = 800,
    parameter int FRAME_H  = 600,
    parameter int STRIPE_W = 32,
    localparam int COL_BITS = $clog2(FRAME_W),
    localparam int ROW_BITS = $clog2(FRAME_H),
    localparam int SUB_BITS = (STRIPE_W > 1) ? $clog2(STRIPE_W) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                step,
    output logic [ROW_BITS-1:0] row,
    output logic [COL_BITS-1:0] col,
    output band_t               band,
    output logic                at_last
);
    localparam logic [COL_BITS-1:0] COL_LAST = COL_BITS'(FRAME_W - 1);
    localparam logic [ROW_BITS-1:0] ROW_LAST = ROW_BITS'(FRAME_H - 1);
    localparam logic [SUB_BITS-1:0] SUB_LAST = SUB_BITS'(STRIPE_W - 1);

    logic [SUB_BITS-1:0] sub;
    logic                line_end;
    logic                band_end;
    band_t               band_nxt;

    assign line_end = (col == COL_LAST);
    assign band_end = (sub == SUB_LAST);
    assign at_last  = line_end && (row == ROW_LAST);

    always_comb begin
        unique case (band)
            BAND_RED:   band_nxt = BAND_GREEN;
            BAND_GREEN: band_nxt = BAND_BLUE;
            default:    band_nxt = BAND_RED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row  <= '0;
            col  <= '0;
            sub  <= '0;
            band <= BAND_RED;
        end else if (step) begin
            if (line_end) begin
                col  <= '0;
                sub  <= '0;
                band <= BAND_RED;
                row  <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
                if (band_end) begin
                    sub  <= '0;
                    band <= band_nxt;
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    // R3
    col_range_chk: assert property (@(posedge clk) disable iff (rst)
        col <= COL_LAST);

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !line_end) |=> (col == $past(col) + 1'b1));

    // R3
    line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && line_end) |=> (col == '0 && row == $past(row) + 1'b1));

    // R5
    band_legal_chk: assert property (@(posedge clk) disable iff (rst)
        band != band_t'(2'd3));

endmodule

// File: rtl/stripe_colour_enc.sv
module stripe_colour_enc
    import stripe_gen_pkg::*;
#(
    parameter int ROW_BITS  = 10,
    parameter int BLACK_ROW = 512
) (
    input  logic [ROW_BITS-1:0] row,
    input  band_t               band,
    output logic [15:0]         pixel
);
    localparam logic [ROW_BITS-1:0] DARK_ROW = ROW_BITS'(BLACK_ROW);
    localparam logic [CHAN_BITS-1:0] FULL = '1;
    localparam logic [CHAN_BITS-1:0] NONE = '0;

    always_comb begin
        if (row == DARK_ROW) begin
            pixel = WORD_BLACK;
        end else begin
            unique case (band)
                BAND_RED:   pixel = pack_rgb555(FULL, NONE, NONE);
                BAND_GREEN: pixel = pack_rgb555(NONE, FULL, NONE);
                default:    pixel = pack_rgb555(NONE, NONE, FULL);
            endcase
        end
    end
endmodule

// File: rtl/stripe_gen_fsm.sv
module stripe_gen_fsm
    import stripe_gen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ready,
    input  logic at_last,
    output logic valid,
    output logic step,
    output logic clear,
    output logic done
);
    gen_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= GEN_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            GEN_IDLE: if (start) state_nxt = GEN_RUN;
            GEN_RUN:  if (ready && at_last) state_nxt = GEN_DONE;
            GEN_DONE: if (start) state_nxt = GEN_RUN;
            default:  state_nxt = GEN_IDLE;
        endcase
    end

    always_comb begin
        valid = 1'b0;
        step  = 1'b0;
        clear = 1'b0;
        done  = 1'b0;
        unique case (state)
            GEN_IDLE: clear = start;
            GEN_RUN: begin
                valid = 1'b1;
                step  = ready && !at_last;
            end
            GEN_DONE: begin
                done  = 1'b1;
                clear = start;
            end
            default: ;
        endcase
    end

    // R8
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && at_last) |=> (done && !valid));

    // R8
    park_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && start) |-> !clear);

endmodule

// File: rtl/stripe_frame_gen.sv
module stripe_frame_gen
    import stripe_gen_pkg::*;
#(
    parameter int FRAME_W   = 800,
    parameter int FRAME_H   = 600,
    parameter int STRIPE_W  = 32,
    parameter int BLACK_ROW = 512,
    localparam int COL_BITS = $clog2(FRAME_W),
    localparam int ROW_BITS = $clog2(FRAME_H)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [15:0]         out_pixel,
    output logic [ROW_BITS-1:0] out_row,
    output logic [COL_BITS-1:0] out_col,
    output logic                out_sof,
    output logic                out_eof,
    output logic                frame_done
);
    logic  step, clear, at_last;
    band_t band;

    stripe_gen_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ready   (out_ready),
        .at_last (at_last),
        .valid   (out_valid),
        .step    (step),
        .clear   (clear),
        .done    (frame_done)
    );

    stripe_raster_cnt #(
        .FRAME_W  (FRAME_W),
        .FRAME_H  (FRAME_H),
        .STRIPE_W (STRIPE_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .step    (step),
        .row     (out_row),
        .col     (out_col),
        .band    (band),
        .at_last (at_last)
    );

    stripe_colour_enc #(
        .ROW_BITS  (ROW_BITS),
        .BLACK_ROW (BLACK_ROW)
    ) u_enc (
        .row   (out_row),
        .band  (band),
        .pixel (out_pixel)
    );

    assign out_sof = out_valid && (out_row == '0) && (out_col == '0);
    assign out_eof = out_valid && at_last;

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_row) && $stable(out_col) && $stable(out_pixel)));

    // R7
    eof_pos_chk: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> (out_row == ROW_BITS'(FRAME_H - 1) && out_col == COL_BITS'(FRAME_W - 1)));

    // R5
    first_red_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sof && BLACK_ROW != 0) |-> (out_pixel == 16'h7C00));

    // R5
    top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        out_pixel[15] == 1'b0);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !frame_done && out_row == '0 && out_col == '0));

endmodule

// File: tb/stripe_frame_gen_test.sv
module stripe_frame_gen_test;
    localparam int W  = 40;
    localparam int H  = 20;
    localparam int SW = 4;
    localparam int BR = 13;
    localparam int RB = $clog2(H);
    localparam int CB = $clog2(W);

    typedef struct packed {
        logic [RB-1:0] row;
        logic [CB-1:0] col;
        logic [15:0]   pix;
        logic          sof;
        logic          eof;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic out_ready = 1'b0;
    logic out_valid, out_sof, out_eof, frame_done;
    logic [15:0] out_pixel;
    logic [RB-1:0] out_row;
    logic [CB-1:0] out_col;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit rand_ready = 1'b0;
    item_t exp_q[$];

    always #5 clk = ~clk;

    stripe_frame_gen #(.FRAME_W(W), .FRAME_H(H), .STRIPE_W(SW), .BLACK_ROW(BR)) uut (
        .clk(clk), .rst(rst), .start(start), .out_ready(out_ready),
        .out_valid(out_valid), .out_pixel(out_pixel), .out_row(out_row),
        .out_col(out_col), .out_sof(out_sof), .out_eof(out_eof),
        .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_pix(input int r, input int c);
        if (r == BR) return 16'h0000;      // R6
        case ((c / SW) % 3)                // R5
            0: return 16'h7C00;
            1: return 16'h03E0;
            default: return 16'h001F;
        endcase
    endfunction

    task automatic push_frame();
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                exp_q.push_back('{row: RB'(r), col: CB'(c), pix: model_pix(r, c),
                                  sof: (r == 0 && c == 0), eof: (r == H-1 && c == W-1)});
    endtask

    task automatic tick();
        @(posedge clk); #1;
        if (rand_ready) out_ready = ($urandom % 3) != 0;
    endtask

    task automatic wait_done();
        while (!frame_done) tick();
    endtask

    // Monitor: scoreboard compare plus stall hold (R4)
    bit hold_prev = 1'b0;
    logic [RB-1:0] h_row;
    logic [CB-1:0] h_col;
    logic [15:0]   h_pix;
    always @(negedge clk) begin
        if (rst) begin
            hold_prev <= 1'b0;
        end else begin
            if (hold_prev) begin
                check(out_valid && out_row == h_row && out_col == h_col && out_pixel == h_pix,
                      "R4 stall hold", int'(out_pixel), int'(h_pix));
            end
            hold_prev <= out_valid && !out_ready;
            h_row <= out_row; h_col <= out_col; h_pix <= out_pixel;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 pixel beyond frame", int'(out_col), -1);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(out_row == e.row && out_col == e.col, "R3 raster position",
                          int'({out_row, out_col}), int'({e.row, e.col}));
                    check(out_pixel == e.pix, "R5/R6 pixel word", int'(out_pixel), int'(e.pix));
                    check(out_sof == e.sof && out_eof == e.eof, "R7 frame markers",
                          int'({out_sof, out_eof}), int'({e.sof, e.eof}));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!out_valid && out_row == 0 && out_col == 0 && !frame_done,
              "R1 reset state", int'({out_valid, frame_done}), 0);

        // Frame 1, ready always high
        push_frame();
        out_ready = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        @(negedge clk);
        // R2
        check(out_valid && out_sof && out_row == 0 && out_col == 0, "R2 launch",
              int'({out_valid, out_sof}), 3);
        wait_done();
        @(negedge clk);
        // R8
        check(!out_valid && frame_done, "R8 finished state", int'({out_valid, frame_done}), 1);
        repeat (5) tick();
        @(negedge clk);
        check(!out_valid && frame_done, "R8 parked", int'({out_valid, frame_done}), 1);
        check(exp_q.size() == 0, "R3 frame complete", exp_q.size(), 0);

        // Frame 2, random back-pressure, stray start mid-frame (R9)
        push_frame();
        rand_ready = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        @(negedge clk);
        check(!frame_done && out_row == 0 && out_col == 0, "R8 relaunch clears done",
              int'(frame_done), 0);
        repeat (150) tick();
        start = 1'b1; tick(); start = 1'b0;   // R9: must be ignored
        wait_done();
        check(exp_q.size() == 0, "R9 sequence continued", exp_q.size(), 0);

        // Mid-frame reset (R10)
        push_frame();
        rand_ready = 1'b0; out_ready = 1'b1;
        start = 1'b1; tick(); start = 1'b0;
        repeat (60) tick();
        rst = 1'b1; tick();
        @(negedge clk);
        exp_q.delete();
        rst = 1'b0;
        tick();
        @(negedge clk);
        check(!out_valid && out_row == 0 && out_col == 0 && !frame_done, "R10 mid-frame reset",
              int'({out_row, out_col}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule